// File: doc/BRIEF.md
# Packetized Scan Chain Shift Engine

The engine loads configuration bits into one of four serial scan chains. Software writes a byte stream into a write FIFO through three push registers. Each bus write appends 1, 2 or 4 bytes. A parser walks the stream and reads a 2-byte header: an opcode byte, then a length byte. It then shifts that many payload bits out on a shared data line. It pulses a shift clock only on the chain that is selected.

Every byte in the stream is either header or payload, so software has to supply exactly the bytes each packet needs. A byte left over after a packet is decoded as the next opcode. A status register shows whether a packet is in flight and how many bytes are queued. Software polls it until the engine is idle, which means the active bit is low and the byte count is zero.

The controller has four named states:
- `ST_IDLE` waits for an opcode byte.
- `ST_LEN` takes the length byte.
- `ST_LOAD` takes the next payload byte.
- `ST_SHIFT` clocks the bits of that byte out.

The transitions are:
- IDLE→LEN on a valid opcode.
- IDLE→IDLE when a bad opcode is discarded.
- LEN→LOAD.
- LOAD→SHIFT.
- SHIFT→LOAD when a byte is used up but bits remain.
- SHIFT→IDLE after the last bit.

Top module: `scan_shift_engine`

## Requirements
- R1: A write with `bus_valid` and `bus_write` high appends bytes to the FIFO, least significant byte first. Address 2 appends 1 byte from `bus_wdata[7:0]`, address 3 appends 2 bytes, and address 4 appends 4 bytes.
- R2: A packet starts with the opcode byte 0x80, followed by a length byte. Bits [6:0] of the length byte hold the payload bit count minus one, so a packet carries 1 to 128 bits.
- R3: A packet takes exactly ceil(bits/8) payload bytes. The unused high bits of its last byte are dropped, and the byte that follows is decoded as a new opcode.
- R4: Payload bits leave on `sc_tdi` least significant bit first, with bytes in FIFO order. Each bit spans one shift clock period: CLK_HALF system clocks low, then CLK_HALF high. `sc_tdi` is stable while the clock is high.
- R5: Address 1 holds the chain select in bits [3:0]. It is readable and writable, and reset clears it. The shift clock appears only on `sc_clk[i]` for the selected chain i.
- R6: While the chain select does not have exactly one bit set, the engine holds its state. It pops no byte and produces no shift clock, and queued bytes stay in the FIFO.
- R7: Status bit 0 (active) rises when a valid opcode is popped. It falls after the falling edge of the final bit's shift clock.
- R8: An opcode other than 0x80 is popped and discarded, and it sets sticky status bit 2. Writing 1 to bit 2 at address 0 clears it.
- R9: A push larger than the free FIFO space is dropped as a whole and sets sticky status bit 1. Writing 1 to bit 1 at address 0 clears it.
- R10: The FIFO holds FIFO_BYTES bytes, 32 by default, which is at least one header plus 16 payload bytes. Status bits [15:8] give the byte count, and reset makes the whole status read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| sc_clk | output | NUM_CHAINS | Shift clock, one per chain |
| sc_tdi | output | 1 | Serial payload data shared by all chains |

## Verification
The assertions assume that a register write lasts exactly one cycle. They also assume that the chain select stays fixed while a packet is shifting, because a change in the middle of a packet would move the shift clock to another chain. The stimulus writes the chain select only while the engine is idle or stalled. It keeps each access to a single cycle. It also builds every packet with exactly the payload bytes its length field calls for, apart from the deliberate bad-opcode byte.

// File: rtl/scs_pkg.sv
package scs_pkg;
    localparam logic [2:0] ADDR_STAT   = 3'd0;
    localparam logic [2:0] ADDR_CHAIN  = 3'd1;
    localparam logic [2:0] ADDR_PUSH8  = 3'd2;
    localparam logic [2:0] ADDR_PUSH16 = 3'd3;
    localparam logic [2:0] ADDR_PUSH32 = 3'd4;
    localparam logic [7:0] OPC_SHIFT   = 8'h80;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEN,
        ST_LOAD,
        ST_SHIFT
    } shf_state_t;
endpackage

// File: rtl/scs_byte_fifo.sv
module scs_byte_fifo #(
    parameter int DEPTH = 32,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    push_n,
    input  logic [31:0]   push_data,
    input  logic          pop,
    output logic [7:0]    head,
    output logic [CW-1:0] count,
    output logic          ovf_evt
);
    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          accept;

    // space is judged before any same-cycle pop
    always_comb begin
        accept  = (push_n != 3'd0) && ((int'(count) + int'(push_n)) <= DEPTH);
        ovf_evt = (push_n != 3'd0) && !accept;
        head    = mem[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            for (int lane = 0; lane < 4; lane++) begin
                if (lane < int'(push_n))
                    mem[wr_ptr + PW'(lane)] <= push_data[8*lane +: 8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (accept) wr_ptr <= wr_ptr + PW'(push_n);
            if (pop)    rd_ptr <= rd_ptr + PW'(1);
            count <= count + (accept ? CW'(push_n) : CW'(0)) - (pop ? CW'(1) : CW'(0));
        end
    end
endmodule

// File: rtl/scs_shifter.sv
module scs_shifter
    import scs_pkg::*;
#(
    parameter int CLK_HALF = 2,
    localparam int DW = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic       fifo_empty,
    input  logic [7:0] head,
    output logic       pop,
    output logic       active,
    output logic       hdr_err_evt,
    output logic       tdi,
    output logic       sck
);
    shf_state_t    state, state_d;
    logic [7:0]    sreg;
    logic [7:0]    bits_left;
    logic [3:0]    byte_bits;
    logic [DW-1:0] div_cnt;
    logic          phase;
    logic          tick;

    assign tick = (int'(div_cnt) == CLK_HALF - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    always_comb begin
        state_d     = state;
        pop         = 1'b0;
        hdr_err_evt = 1'b0;
        unique case (state)
            ST_IDLE: if (go && !fifo_empty) begin
                pop = 1'b1;
                if (head == OPC_SHIFT) state_d = ST_LEN;
                else                   hdr_err_evt = 1'b1;
            end
            ST_LEN: if (go && !fifo_empty) begin
                pop     = 1'b1;
                state_d = ST_LOAD;
            end
            ST_LOAD: if (go && !fifo_empty) begin
                pop     = 1'b1;
                state_d = ST_SHIFT;
            end
            ST_SHIFT: if (go && tick && phase) begin
                if (bits_left == 8'd1)      state_d = ST_IDLE;
                else if (byte_bits == 4'd1) state_d = ST_LOAD;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        tdi = (state == ST_SHIFT) & sreg[0];
        sck = (state == ST_SHIFT) & phase;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg      <= '0;
            bits_left <= '0;
            byte_bits <= '0;
            div_cnt   <= '0;
            phase     <= 1'b0;
            active    <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE:  if (pop && head == OPC_SHIFT) active <= 1'b1;
                ST_LEN:   if (pop) bits_left <= {1'b0, head[6:0]} + 8'd1;
                ST_LOAD:  if (pop) begin
                    sreg      <= head;
                    byte_bits <= (bits_left > 8'd8) ? 4'd8 : bits_left[3:0];
                    div_cnt   <= '0;
                    phase     <= 1'b0;
                end
                ST_SHIFT: if (go) begin
                    if (tick) begin
                        div_cnt <= '0;
                        phase   <= ~phase;
                        if (phase) begin
                            sreg      <= sreg >> 1;
                            bits_left <= bits_left - 8'd1;
                            byte_bits <= byte_bits - 4'd1;
                            if (bits_left == 8'd1) active <= 1'b0;
                        end
                    end else begin
                        div_cnt <= div_cnt + DW'(1);
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/scan_shift_engine.sv
module scan_shift_engine
    import scs_pkg::*;
#(
    parameter int NUM_CHAINS = 4,
    parameter int FIFO_BYTES = 32,
    parameter int CLK_HALF   = 2,
    localparam int CW = $clog2(FIFO_BYTES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_valid,
    input  logic                  bus_write,
    input  logic [2:0]            bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    output logic [NUM_CHAINS-1:0] sc_clk,
    output logic                  sc_tdi
);
    logic [NUM_CHAINS-1:0] chain_en_q;
    logic                  ovf_q, herr_q;
    logic [2:0]            push_n;
    logic                  wr_en;
    logic                  go;
    logic [7:0]            head;
    logic [CW-1:0]         fifo_cnt;
    logic                  ovf_evt, pop, sh_active, herr_evt, sck;

    assign wr_en = bus_valid && bus_write;
    assign go    = ($countones(chain_en_q) == 1);

    always_comb begin
        push_n = 3'd0;
        if (wr_en) begin
            unique case (bus_addr)
                ADDR_PUSH8:  push_n = 3'd1;
                ADDR_PUSH16: push_n = 3'd2;
                ADDR_PUSH32: push_n = 3'd4;
                default:     push_n = 3'd0;
            endcase
        end
    end

    scs_byte_fifo #(.DEPTH(FIFO_BYTES)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push_n(push_n), .push_data(bus_wdata),
        .pop(pop), .head(head), .count(fifo_cnt), .ovf_evt(ovf_evt)
    );

    scs_shifter #(.CLK_HALF(CLK_HALF)) u_shift (
        .clk(clk), .rst_n(rst_n), .go(go), .fifo_empty(fifo_cnt == '0),
        .head(head), .pop(pop), .active(sh_active), .hdr_err_evt(herr_evt),
        .tdi(sc_tdi), .sck(sck)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_en_q <= '0;
            ovf_q      <= 1'b0;
            herr_q     <= 1'b0;
        end else begin
            if (wr_en && bus_addr == ADDR_CHAIN) chain_en_q <= bus_wdata[NUM_CHAINS-1:0];
            ovf_q  <= (ovf_q  & ~(wr_en && bus_addr == ADDR_STAT && bus_wdata[1])) | ovf_evt;
            herr_q <= (herr_q & ~(wr_en && bus_addr == ADDR_STAT && bus_wdata[2])) | herr_evt;
        end
    end

    always_comb begin
        sc_clk    = {NUM_CHAINS{sck}} & chain_en_q;
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_STAT: begin
                bus_rdata[0]    = sh_active;
                bus_rdata[1]    = ovf_q;
                bus_rdata[2]    = herr_q;
                bus_rdata[15:8] = 8'(fifo_cnt);
            end
            ADDR_CHAIN: bus_rdata[NUM_CHAINS-1:0] = chain_en_q;
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/scs_checker.sv
module scs_checker #(
    parameter int NUM_CHAINS = 4,
    parameter int DEPTH = 32,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_CHAINS-1:0] sc_clk,
    input logic                  sc_tdi,
    input logic [NUM_CHAINS-1:0] chain_en,
    input logic [CW-1:0]         fifo_count,
    input logic                  active
);
    assert_one_clock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sc_clk));

    assert_single_chain_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_clk != '0) |-> ($countones(chain_en) == 1));

    assert_tdi_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((sc_clk != '0) && ($past(sc_clk) != '0)) |-> $stable(sc_tdi));

    assert_active_clock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_clk != '0) |-> active);

    assert_fifo_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fifo_count) <= DEPTH);
endmodule

bind scan_shift_engine scs_checker #(.NUM_CHAINS(NUM_CHAINS), .DEPTH(FIFO_BYTES)) u_scs_chk (
    .clk(clk), .rst_n(rst_n), .sc_clk(sc_clk), .sc_tdi(sc_tdi),
    .chain_en(chain_en_q), .fifo_count(fifo_cnt), .active(sh_active)
);

// File: tb/test_scan_shift_engine.sv
module test_scan_shift_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  sc_clk;
    logic        sc_tdi;

    int compared = 0, mismatched = 0, pulses = 0;
    int exp_q[$];
    logic [3:0] prev_clk = '0;
    logic [31:0] rd;

    always #5 clk = ~clk;

    scan_shift_engine i_scan_shift_engine (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sc_clk(sc_clk), .sc_tdi(sc_tdi)
    );

    task automatic chk(string req, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // scoreboard driver side: queue the bits each packet should produce
    task automatic exp_bits(int ch, logic [127:0] data, int n);
        for (int i = 0; i < n; i++) exp_q.push_back(ch * 2 + int'(data[i]));
    endtask

    // monitor: compare at every rising edge of a chain clock
    always @(negedge clk) begin
        if (sc_clk != 4'd0 && prev_clk == 4'd0) begin
            int got, ch;
            ch = 0;
            for (int i = 0; i < 4; i++) if (sc_clk[i]) ch = i;
            got = ch * 2 + int'(sc_tdi);
            pulses++;
            if (exp_q.size() == 0) chk("R4 unexpected shift bit", got, -1);
            else chk("R4/R5 shifted chain*2+bit", got, exp_q.pop_front());
        end
        prev_clk <= sc_clk;
    end

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rdreg(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle(string req);
        logic [31:0] s;
        int n = 0;
        do begin
            rdreg(3'd0, s);
            n++;
        end while ((s[0] || s[15:8] != 8'd0) && n < 5000);
        chk({req, " idle reached"}, int'(n < 5000), 1);
        repeat (4) @(negedge clk);
        chk({req, " scoreboard drained"}, exp_q.size(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        int p0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rdreg(3'd0, rd); chk("R10 reset status", int'(rd), 0);
        rdreg(3'd1, rd); chk("R5 reset chain select", int'(rd), 0);
        chk("R5 reset clocks", int'(sc_clk), 0);

        // R2 R4: 8-bit packet on chain 0 via byte pushes
        wr(3'd1, 32'h1);
        rdreg(3'd1, rd); chk("R5 chain select readback", int'(rd), 1);
        exp_bits(0, 128'hA5, 8);
        wr(3'd2, 32'h80); wr(3'd2, 32'h07); wr(3'd2, 32'hA5);
        repeat (4) @(negedge clk);
        rdreg(3'd0, rd); chk("R7 active while shifting", int'(rd[0]), 1);
        wait_idle("R2 byte packet");
        rdreg(3'd0, rd); chk("R7 active low after packet", int'(rd[0]), 0);

        // R6 R10 R1: queue full 128-bit packet while no chain is selected
        wr(3'd1, 32'h0);
        wr(3'd3, 32'h0000_7F80);
        wr(3'd4, 32'h1234_5678); wr(3'd4, 32'h9ABC_DEF0);
        wr(3'd4, 32'h0F1E_2D3C); wr(3'd4, 32'hC001_D00D);
        repeat (20) @(negedge clk);
        rdreg(3'd0, rd); chk("R10 R1 count holds 18 bytes", int'(rd[15:8]), 18);
        chk("R6 stalled active low", int'(rd[0]), 0);
        exp_bits(1, {32'hC001_D00D, 32'h0F1E_2D3C, 32'h9ABC_DEF0, 32'h1234_5678}, 128);
        wr(3'd1, 32'h2);
        wait_idle("R2 R4 128-bit packet");

        // R6: two chains selected suppresses shifting
        wr(3'd1, 32'h3);
        p0 = pulses;
        wr(3'd2, 32'h80); wr(3'd2, 32'h03); wr(3'd2, 32'h0A);
        repeat (40) @(negedge clk);
        rdreg(3'd0, rd); chk("R6 bytes kept with two chains", int'(rd[15:8]), 3);
        chk("R6 no pulses with two chains", pulses - p0, 0);
        exp_bits(3, 128'h0A, 4);
        // R3: back-to-back packets, partial last byte then 1-bit packet
        exp_bits(3, 128'h234, 12);
        exp_bits(3, 128'h1, 1);
        wr(3'd4, 32'hF234_0B80);
        wr(3'd3, 32'h0080); wr(3'd2, 32'h01);
        wr(3'd1, 32'h8);
        wait_idle("R3 residual bytes");
        rdreg(3'd0, rd); chk("R3 no stray opcode error", int'(rd[2]), 0);

        // R8: bad opcode discarded
        wr(3'd1, 32'h1);
        p0 = pulses;
        wr(3'd2, 32'h11);
        repeat (6) @(negedge clk);
        rdreg(3'd0, rd);
        chk("R8 error flag", int'(rd[2]), 1);
        chk("R8 byte discarded", int'(rd[15:8]), 0);
        chk("R8 no pulses", pulses - p0, 0);
        wr(3'd0, 32'h4);
        rdreg(3'd0, rd); chk("R8 error cleared", int'(rd[2]), 0);

        // R9: fill the FIFO, then overflow
        wr(3'd1, 32'h0);
        for (int k = 0; k < 8; k++) wr(3'd4, {8'(k), 8'(8'hC0 + k), 8'h0F, 8'h80});
        rdreg(3'd0, rd); chk("R10 full count", int'(rd[15:8]), 32);
        chk("R9 no overflow yet", int'(rd[1]), 0);
        wr(3'd2, 32'h80);
        rdreg(3'd0, rd);
        chk("R9 overflow flag", int'(rd[1]), 1);
        chk("R9 push dropped whole", int'(rd[15:8]), 32);
        wr(3'd0, 32'h2);
        rdreg(3'd0, rd); chk("R9 overflow cleared", int'(rd[1]), 0);
        for (int k = 0; k < 8; k++) exp_bits(2, {8'(k), 8'(8'hC0 + k)}, 16);
        wr(3'd1, 32'h4);
        wait_idle("R9 drain after overflow");
        rdreg(3'd0, rd); chk("R9 R8 status clean", int'(rd), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule